// File: doc/BRIEF.md
# Dual Bidirectional Parallel Port Register File

This block is the register front end of a bus-attached parallel I/O peripheral with two 8-bit ports, A and B. The host bus reaches it through a register address, read and write strobes and an 8-bit data bus. Each port has a direction register and an output latch. The block drives the port pins from these registers. On a read it returns, for each bit, either the latched output value or the live pin level, depending on that bit's direction.

Each port can be driven by several external sources at once. Their levels are combined as a wired-AND, so any source pulling a bit low wins. Accessing a port's main data register sends a one-cycle clear pulse toward the interrupt controller for that port's two control-line flags. Port A also has a quiet alias that reaches the same latch without sending any clear pulse. A timer input can take over bit 7 of port B. The strobed handshake pulses on the control lines are handled outside this block.

Top module: `pio_regs`

## Requirements
- R1: While reset is held, and after it is released with no writes, both direction registers read 0x00, both output enables are 0, the flag-clear outputs are 0, and with every source idle at 0xFF the port reads at offsets 0x0 and 0x1 return 0xFF.
- R2: Only the low 4 bits of the bus address are decoded, so bus address 0x11 reaches the same register as 0x01.
- R3: Offset 0x2 holds the port B direction register and offset 0x3 holds the port A direction register. Each reads back the last value written.
- R4: A port read (offset 0x0 for B; 0x1 or 0xF for A) returns the output latch bit where the direction bit is 1 and the pin input bit where it is 0.
- R5: A port's pin input is the bitwise AND of all its sources.
- R6: Port pins present the output latch, and each bit's output enable equals its direction bit.
- R7: A read or write at offset 0x1 makes flag_clr[1:0] (CA2, CA1) equal 2'b11 for the one cycle after that clock edge. A read or write at offset 0x0 does the same for flag_clr[3:2] (CB2, CB1). In all other cycles these bits are 0.
- R8: Offset 0xF reads and writes the port A output latch but leaves flag_clr at 0.
- R9: While tmr_pb7_en is 1, bit 7 of the port B pins and of the port B read value both equal tmr_pb7_val.
- R10: Registers change only on a clock edge with the write strobe high. Writes to unmapped offsets (0x4 to 0xE) change nothing, and reads of those offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | BUS_AW (8) | Register address; only the low 4 bits are decoded |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| pa_src | input | NSRC*8 | Port A pin levels, one byte per source |
| pb_src | input | NSRC*8 | Port B pin levels, one byte per source |
| pa_out | output | 8 | Port A pin output values |
| pa_oe | output | 8 | Port A per-bit output enables |
| pb_out | output | 8 | Port B pin output values |
| pb_oe | output | 8 | Port B per-bit output enables |
| tmr_pb7_en | input | 1 | Timer takeover of port B bit 7 |
| tmr_pb7_val | input | 1 | Level used for bit 7 during the takeover |
| flag_clr | output | 4 | One-cycle clear pulses: bit0 CA1, bit1 CA2, bit2 CB1, bit3 CB2 |

## Verification
The bench goes after the mixed read. With a direction value of 0x0F, output latch 0x5A and idle pins, the read must return 0xFA. A swapped mux would return 0x5F instead. It drives two sources with disjoint patterns, where a wired-OR would read 0xFF instead of 0x00. It also uses address aliases above 0x0F, which a decoder using the full address would treat as unmapped.

It separates the quiet alias from the main port A register: a design that also pulses on 0xF would raise a clear pulse there. It checks that the pulse lasts exactly one cycle. It checks that writes to unmapped offsets leave every register untouched. It also checks that the bit 7 takeover applies to both the pins and the read value, since a design might change only one of them.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int DATA_W = 8;
  localparam int REG_AW = 4;
  localparam int FLAG_N = 4;

  typedef enum logic [REG_AW-1:0] {
    OFS_B_DATA  = 4'h0,
    OFS_A_DATA  = 4'h1,
    OFS_B_DIR   = 4'h2,
    OFS_A_DIR   = 4'h3,
    OFS_A_QUIET = 4'hF
  } reg_ofs_e;

  localparam int FLG_CA1 = 0;
  localparam int FLG_CA2 = 1;
  localparam int FLG_CB1 = 2;
  localparam int FLG_CB2 = 3;
endpackage

// File: rtl/pio_wand.sv
module pio_wand #(
  parameter int W = 8,
  parameter int N = 2
) (
  input  logic [N*W-1:0] src,
  output logic [W-1:0]   res
);
  always_comb begin
    res = '1;
    for (int i = 0; i < N; i++) begin
      res = res & src[i*W +: W];
    end
  end
endmodule

// File: rtl/pio_decode.sv
module pio_decode
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              rd,
  input  logic              wr,
  output logic              wr_a_data,
  output logic              wr_b_data,
  output logic              wr_a_dir,
  output logic              wr_b_dir,
  output logic [FLAG_N-1:0] flag_clr
);
  logic              acc;
  logic [FLAG_N-1:0] flag_d;
  logic [FLAG_N-1:0] flag_q;

  assign acc = rd | wr;

  always_comb begin
    wr_a_data = 1'b0;
    wr_b_data = 1'b0;
    wr_a_dir  = 1'b0;
    wr_b_dir  = 1'b0;
    flag_d    = '0;
    case (reg_addr)
      OFS_B_DATA: begin
        wr_b_data = wr;
        flag_d[FLG_CB1] = acc;
        flag_d[FLG_CB2] = acc;
      end
      OFS_A_DATA: begin
        wr_a_data = wr;
        flag_d[FLG_CA1] = acc;
        flag_d[FLG_CA2] = acc;
      end
      OFS_B_DIR:   wr_b_dir  = wr;
      OFS_A_DIR:   wr_a_dir  = wr;
      OFS_A_QUIET: wr_a_data = wr;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag_clr = flag_q;

  // R7: a main port A access is followed by a CA pair pulse
  p_pulse_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && reg_addr == 4'h1) |=> (flag_clr[1:0] == 2'b11));

  // R8: the quiet alias never produces a pulse
  p_alias_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && reg_addr == 4'hF) |=> (flag_clr == 4'b0000));
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter bit HAS_OVR = 1'b0,
  parameter int OVR_BIT = DATA_W-1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data,
  input  logic              wr_dir,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] pin_in,
  input  logic              ovr_en,
  input  logic              ovr_val,
  output logic [DATA_W-1:0] dir_q,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_oe,
  output logic [DATA_W-1:0] rd_val
);
  logic [DATA_W-1:0] out_q, out_d, dir_d;
  logic [DATA_W-1:0] mix;

  always_comb begin
    out_d = wr_data ? wdata : out_q;
    dir_d = wr_dir  ? wdata : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      out_q <= out_d;
      dir_q <= dir_d;
    end
  end

  assign mix    = (dir_q & out_q) | (~dir_q & pin_in);
  assign pin_oe = dir_q;

  generate
    if (HAS_OVR) begin : g_ovr
      always_comb begin
        pin_out = out_q;
        rd_val  = mix;
        if (ovr_en) begin
          pin_out[OVR_BIT] = ovr_val;
          rd_val[OVR_BIT]  = ovr_val;
        end
      end
    end else begin : g_plain
      logic unused_ovr;
      assign unused_ovr = ovr_en ^ ovr_val;
      assign pin_out = out_q;
      assign rd_val  = mix;
    end
  endgenerate

  // R6: a direction write shows up on the output enables after the edge
  p_dir_to_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (pin_oe == $past(wdata)));

  // R10: with no write strobe the latch holds
  p_latch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data |=> $stable(out_q));
endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int BUS_AW = 8,
  parameter int NSRC   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [BUS_AW-1:0]      bus_addr,
  input  logic                   bus_rd,
  input  logic                   bus_wr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic [NSRC*DATA_W-1:0] pa_src,
  input  logic [NSRC*DATA_W-1:0] pb_src,
  output logic [DATA_W-1:0]      pa_out,
  output logic [DATA_W-1:0]      pa_oe,
  output logic [DATA_W-1:0]      pb_out,
  output logic [DATA_W-1:0]      pb_oe,
  input  logic                   tmr_pb7_en,
  input  logic                   tmr_pb7_val,
  output logic [FLAG_N-1:0]      flag_clr
);
  localparam int PB7 = DATA_W-1;

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [REG_AW-1:0] reg_addr;
  logic              unused_addr_hi;
  logic              wr_a_data, wr_b_data, wr_a_dir, wr_b_dir;
  logic [DATA_W-1:0] pa_pin, pb_pin;
  logic [DATA_W-1:0] pa_dir, pb_dir, pa_rd, pb_rd;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign reg_addr       = bus_addr[REG_AW-1:0];
  assign unused_addr_hi = ^bus_addr;

  pio_decode i_dec (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .reg_addr  (reg_addr),
    .rd        (bus_rd),
    .wr        (bus_wr),
    .wr_a_data (wr_a_data),
    .wr_b_data (wr_b_data),
    .wr_a_dir  (wr_a_dir),
    .wr_b_dir  (wr_b_dir),
    .flag_clr  (flag_clr)
  );

  pio_wand #(.W(DATA_W), .N(NSRC)) i_wand_a (.src(pa_src), .res(pa_pin));
  pio_wand #(.W(DATA_W), .N(NSRC)) i_wand_b (.src(pb_src), .res(pb_pin));

  pio_port #(.HAS_OVR(1'b0)) i_port_a (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_data (wr_a_data),
    .wr_dir  (wr_a_dir),
    .wdata   (bus_wdata),
    .pin_in  (pa_pin),
    .ovr_en  (1'b0),
    .ovr_val (1'b0),
    .dir_q   (pa_dir),
    .pin_out (pa_out),
    .pin_oe  (pa_oe),
    .rd_val  (pa_rd)
  );

  pio_port #(.HAS_OVR(1'b1), .OVR_BIT(PB7)) i_port_b (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_data (wr_b_data),
    .wr_dir  (wr_b_dir),
    .wdata   (bus_wdata),
    .pin_in  (pb_pin),
    .ovr_en  (tmr_pb7_en),
    .ovr_val (tmr_pb7_val),
    .dir_q   (pb_dir),
    .pin_out (pb_out),
    .pin_oe  (pb_oe),
    .rd_val  (pb_rd)
  );

  always_comb begin
    case (reg_addr)
      OFS_B_DATA:  bus_rdata = pb_rd;
      OFS_A_DATA:  bus_rdata = pa_rd;
      OFS_B_DIR:   bus_rdata = pb_dir;
      OFS_A_DIR:   bus_rdata = pa_dir;
      OFS_A_QUIET: bus_rdata = pa_rd;
      default:     bus_rdata = '0;
    endcase
  end

  // R9: the timer takeover reaches the port B bit 7 pin
  p_pb7_takeover_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    tmr_pb7_en |-> (pb_out[PB7] == tmr_pb7_val));
endmodule

// File: tb/test_pio_regs.sv
`timescale 1ns/1ps
module test_pio_regs;
  localparam int NSRC = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [7:0]        bus_addr;
  logic              bus_rd, bus_wr;
  logic [7:0]        bus_wdata, bus_rdata;
  logic [NSRC*8-1:0] pa_src, pb_src;
  logic [7:0]        pa_out, pa_oe, pb_out, pb_oe;
  logic              tmr_pb7_en, tmr_pb7_val;
  logic [3:0]        flag_clr;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // reference model
  logic [7:0] m_a_out, m_a_dir, m_b_out, m_b_dir;

  always #2.5 clk = ~clk;

  pio_regs #(.BUS_AW(8), .NSRC(NSRC)) i_pio_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_src(pa_src), .pb_src(pb_src), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_out(pb_out), .pb_oe(pb_oe), .tmr_pb7_en(tmr_pb7_en),
    .tmr_pb7_val(tmr_pb7_val), .flag_clr(flag_clr)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] wand_of(input logic [NSRC*8-1:0] s);
    logic [7:0] r = 8'hFF;
    for (int i = 0; i < NSRC; i++) r = r & s[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [7:0] exp_port_a();
    return (m_a_dir & m_a_out) | (~m_a_dir & wand_of(pa_src));
  endfunction

  function automatic logic [7:0] exp_port_b();
    logic [7:0] r = (m_b_dir & m_b_out) | (~m_b_dir & wand_of(pb_src));
    if (tmr_pb7_en) r[7] = tmr_pb7_val;
    return r;
  endfunction

  function automatic logic [7:0] exp_pb_pins();
    logic [7:0] r = m_b_out;
    if (tmr_pb7_en) r[7] = tmr_pb7_val;
    return r;
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    case (a[3:0])
      4'h0: return exp_port_b();
      4'h1: return exp_port_a();
      4'h2: return m_b_dir;
      4'h3: return m_a_dir;
      4'hF: return exp_port_a();
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [3:0] exp_flags(input logic [7:0] a, input bit acc);
    if (!acc) return 4'b0000;
    if (a[3:0] == 4'h1) return 4'b0011;
    if (a[3:0] == 4'h0) return 4'b1100;
    return 4'b0000;
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic op(input logic [7:0] a, input bit wr, input bit rd,
                    input logic [7:0] d, input string tag);
    bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = d;
    #1;
    if (rd) chk({tag, " read"}, bus_rdata, exp_read(a));
    chk("R6 pa_out", pa_out, m_a_out);
    chk("R6 pa_oe", pa_oe, m_a_dir);
    chk("R9 pb_out", pb_out, exp_pb_pins());
    chk("R6 pb_oe", pb_oe, m_b_dir);
    @(negedge clk);
    chk({tag, " R7 flag_clr"}, {4'h0, flag_clr}, {4'h0, exp_flags(a, wr | rd)});
    if (wr) begin
      case (a[3:0])
        4'h0: m_b_out = d;
        4'h1, 4'hF: m_a_out = d;
        4'h2: m_b_dir = d;
        4'h3: m_a_dir = d;
        default: ;
      endcase
    end
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic idle(input string tag);
    bus_rd = 1'b0; bus_wr = 1'b0;
    @(negedge clk);
    chk({tag, " flag_clr idle"}, {4'h0, flag_clr}, 8'h00);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; bus_addr = 8'h00; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
    pa_src = '1; pb_src = '1; tmr_pb7_en = 1'b0; tmr_pb7_val = 1'b0;
    m_a_out = 8'h00; m_a_dir = 8'h00; m_b_out = 8'h00; m_b_dir = 8'h00;
    repeat (3) @(negedge clk);
    // R1 during reset
    bus_addr = 8'h00; #1 chk("R1 B read in reset", bus_rdata, 8'hFF);
    bus_addr = 8'h01; #1 chk("R1 A read in reset", bus_rdata, 8'hFF);
    chk("R1 pa_oe in reset", pa_oe, 8'h00);
    chk("R1 pb_oe in reset", pb_oe, 8'h00);
    chk("R1 flag_clr in reset", {4'h0, flag_clr}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 after release
    op(8'h02, 0, 1, 8'h00, "R1 B dir");
    op(8'h03, 0, 1, 8'h00, "R1 A dir");
    op(8'h00, 0, 1, 8'h00, "R1 B port");
    op(8'h01, 0, 1, 8'h00, "R1 A port");
    // R3 direction readback
    op(8'h02, 1, 0, 8'hAA, "R3 write");
    op(8'h02, 0, 1, 8'h00, "R3 B dir");
    op(8'h03, 1, 0, 8'h55, "R3 write");
    op(8'h03, 0, 1, 8'h00, "R3 A dir");
    // R4 mixed read: dir 0x0F, latch 0x5A, idle pins -> 0xFA
    op(8'h03, 1, 0, 8'h0F, "R4 setup");
    op(8'h01, 1, 0, 8'h5A, "R4 setup");
    op(8'h01, 0, 1, 8'h00, "R4 mixed");
    chk("R4 mixed const", bus_rdata, 8'hFA);
    // R5 wired-AND of disjoint sources
    op(8'h03, 1, 0, 8'h00, "R5 setup");
    pa_src = {8'hF0, 8'h0F};
    op(8'h01, 0, 1, 8'h00, "R5 wand");
    chk("R5 wand const", bus_rdata, 8'h00);
    pa_src = {8'hFE, 8'h7F};
    op(8'h01, 0, 1, 8'h00, "R5 wand2");
    pa_src = '1;
    // R2 address alias
    op(8'h03, 1, 0, 8'hFF, "R2 setup");
    op(8'h11, 1, 0, 8'h42, "R2 alias write");
    op(8'h01, 0, 1, 8'h00, "R2 alias readback");
    op(8'hF0, 1, 0, 8'h3C, "R2 alias B");
    op(8'h00, 0, 1, 8'h00, "R2 alias B readback");
    // R8 quiet alias
    op(8'h0F, 1, 0, 8'h88, "R8 quiet write");
    op(8'h0F, 0, 1, 8'h00, "R8 quiet read");
    op(8'h01, 0, 1, 8'h00, "R8 shared latch");
    // R7 pulse length
    op(8'h00, 1, 0, 8'h11, "R7 B write");
    idle("R7 single cycle");
    op(8'h01, 0, 1, 8'h00, "R7 A read");
    op(8'h00, 0, 1, 8'h00, "R7 back to back");
    idle("R7 single cycle");
    // R10 unmapped writes ignored
    for (int k = 4; k < 15; k++) begin
      op(8'(k), 1, 0, 8'hC3, "R10 unmapped write");
      op(8'(k), 0, 1, 8'h00, "R10 unmapped read");
    end
    op(8'h00, 0, 1, 8'h00, "R10 B port unchanged");
    op(8'h01, 0, 1, 8'h00, "R10 A port unchanged");
    op(8'h02, 0, 1, 8'h00, "R10 B dir unchanged");
    op(8'h03, 0, 1, 8'h00, "R10 A dir unchanged");
    // R9 takeover with bit 7 as input and as output
    op(8'h02, 1, 0, 8'h00, "R9 setup");
    tmr_pb7_en = 1'b1; tmr_pb7_val = 1'b0;
    op(8'h00, 0, 1, 8'h00, "R9 takeover input");
    op(8'h02, 1, 0, 8'hFF, "R9 setup");
    op(8'h00, 1, 0, 8'h00, "R9 setup");
    tmr_pb7_val = 1'b1;
    op(8'h00, 0, 1, 8'h00, "R9 takeover output");
    tmr_pb7_en = 1'b0;
    op(8'h00, 0, 1, 8'h00, "R9 released");
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      int sel;
      sel = $urandom_range(0, 9);
      a = 8'($urandom);
      if (sel < 7) a = {a[7:4], 4'(($urandom_range(0, 4) == 4) ? 4'hF : 4'($urandom_range(0, 3)))};
      pa_src = NSRC*8'($urandom) | (($urandom_range(0, 1) == 1) ? '1 : '0);
      pb_src = NSRC*8'($urandom);
      tmr_pb7_en = 1'($urandom);
      tmr_pb7_val = 1'($urandom);
      case ($urandom_range(0, 2))
        0: op(a, 1, 0, 8'($urandom), "R4 random write");
        1: op(a, 0, 1, 8'h00, "R4 random read");
        default: op(a, 0, 0, 8'h00, "R10 random idle");
      endcase
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule